// File: doc/BRIEF.md
# Programmable-Length Serial Shift Register

This block is a one-bit serial delay line whose length runs from 1 to 64 stages. A six-bit length code gives the length: the code value plus one. A shift takes one new bit. The bit comes from one of two serial data inputs, and a select line picks which one. The output shows the bit that was shifted in exactly "length" shifts earlier. A complementary output always carries its inverse.

Shifts are not caused by the system clock directly. Two strobe pins, one qualified on a rising edge and one on a falling edge, are sampled on the system clock and edge-detected:

- A rise of the positive strobe pin shifts the register while the negative strobe pin is low.
- A fall of the negative strobe pin shifts the register while the positive strobe pin is high.

If both qualifying edges are seen in the same sample, the register makes only one shift.

An active-high master clear forces the outputs to their cleared values at once, with no clock needed. While it stays high it empties the storage and blocks shifting. A synchronous active-low system reset also empties the storage and the edge history.

Top module: `varlen_shift_reg`

## Requirements
- R1: With `len_sel` = n (0..63), `q` equals the bit shifted in n+1 shifts ago, or 0 if fewer than n+1 shifts have happened since the last clear.
- R2: A low-to-high change of `ck_pos`, seen while `ck_neg` is low, shifts the register by one.
- R3: A high-to-low change of `ck_neg`, seen while `ck_pos` is high, shifts the register by one.
- R4: These strobe changes never shift the register: a `ck_pos` rise while `ck_neg` is high, a `ck_neg` fall while `ck_pos` is low, any `ck_pos` fall, and any `ck_neg` rise.
- R5: When a `ck_pos` rise and a `ck_neg` fall both qualify in the same sample, the register makes exactly one shift.
- R6: With `sel_a` = 1 the shifted bit is `din_a`. With `sel_a` = 0 it is `din_b`.
- R7: While `clr` is 1, `q` is 0 and `q_n` is 1 at once, with no clock needed. Every clock edge with `clr` high empties the storage. Strobe edges are ignored while `clr` is high, and releasing `clr` causes no shift.
- R8: `q_n` is always the inverse of `q`.
- R9: Changing `len_sel` moves the output tap at once, without a clock edge, and does not change the stored bits.
- R10: A clock edge with `rst_n` low empties the storage and the strobe history. Releasing `rst_n` while a strobe pin is already high causes no shift.
- R11: Take a strobe pin change that is present before clock edge k. The shift happens at edge k+1, and the data and select values are sampled at edge k+1. `q` for length 1 changes after edge k+1, not after edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| clr | input | 1 | Active-high master clear; acts on the outputs without a clock |
| len_sel | input | 6 | Length code; length = value + 1 |
| ck_pos | input | 1 | Strobe pin qualified on its rising edge |
| ck_neg | input | 1 | Strobe pin qualified on its falling edge |
| sel_a | input | 1 | Data source select: 1 = din_a, 0 = din_b |
| din_a | input | 1 | Serial data input A |
| din_b | input | 1 | Serial data input B |
| q | output | 1 | Serial output at the selected length |
| q_n | output | 1 | Inverse of q |

## Verification
Every length from 1 to 64 is filled with random bits past its depth. This shows whether the tap sits at the right stage and whether bits enter at the head. The lengths alternate between the two strobe modes. The data source alternates, and the unused input always carries the opposite bit, so any wrong source selection changes `q`.

Separate sequences cover the remaining cases:

- Each non-qualifying strobe change is driven alone, with a 1 waiting at the input, so a wrong shift shows at length 1.
- The simultaneous double edge is driven and must give exactly one shift.
- A full 64-bit fill is swept across all lengths with no shifting, which separates tap movement from data movement.
- Strobe activity is driven during clear and during reset, with pins held high at release, to expose spurious shifts and incomplete clearing.

// File: rtl/vsr_pkg.sv
// Package: shared types for the programmable-length shift register.
// Assumes: all users run on a single system clock.
package vsr_pkg;

    // One sample of the two strobe pins.
    typedef struct packed {
        logic pos;   // rising-edge-qualified pin
        logic neg;   // falling-edge-qualified pin
    } strobe_pair_t;

    // Number of bits needed to address a chain of the given depth.
    function automatic int sel_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/vsr_strobe.sv
// Module: vsr_strobe
// Turns the two strobe pins into a single-cycle shift request.
// The pins are registered once, and the previous sample is kept.
// A rise of pos with neg low, or a fall of neg with pos high, gives a
// one-cycle request; both together still give one request.
// Assumes: pins are stable for at least one clk period between changes.
// During reset or clear both samples follow the pin, so release never
// looks like an edge.
module vsr_strobe
    import vsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ck_pos,
    input  logic ck_neg,
    output logic step
);

    strobe_pair_t smp_q;   // current registered sample
    strobe_pair_t prv_q;   // sample from the previous cycle
    strobe_pair_t pin_now;
    logic         rise_ok;
    logic         fall_ok;

    // Pack the raw pins into the sample type.
    always_comb begin
        pin_now.pos = ck_pos;
        pin_now.neg = ck_neg;
    end

    // Sample the pins; during reset or clear, load both stages with the pin.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            smp_q <= pin_now;
            prv_q <= pin_now;
        end else begin
            smp_q <= pin_now;
            prv_q <= smp_q;
        end
    end

    // Qualify each edge against the level of the other pin.
    always_comb begin
        rise_ok = smp_q.pos & ~prv_q.pos & ~smp_q.neg;
        fall_ok = prv_q.neg & ~smp_q.neg & smp_q.pos;
        step    = (rise_ok | fall_ok) & ~clr & rst_n;
    end

    AST_STEP_QUIET_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr |-> !step); // R7
    AST_NO_STEP_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $past(clr) |-> !step); // R7
    AST_NO_STEP_AFTER_RESET: assert property (@(posedge clk) (rst_n && !$past(rst_n)) |-> !step); // R10
    AST_STEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) step |=> !step); // R5

endmodule

// File: rtl/vsr_chain.sv
// Module: vsr_chain
// The storage: a DEPTH-stage serial chain. Stage 0 holds the newest bit.
// A step moves every stage up by one and loads din into stage 0.
// Assumes: step is a single-cycle request from vsr_strobe.
// Clear and reset both empty the chain on the clock edge.
module vsr_chain #(
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             din,
    output logic [DEPTH-1:0] stages
);

    logic [DEPTH-1:0] nxt;

    // Build the shifted image, one stage per generate iteration.
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign nxt[i] = din;
        end else begin : g_body
            assign nxt[i] = stages[i-1];
        end
    end

    // Hold, clear or shift the chain.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stages <= '0;
        end else if (step) begin
            stages <= nxt;
        end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (stages == '0)); // R7
    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!step && !clr) |=> $stable(stages)); // R4
    AST_HEAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n) (step && !clr) |=> (stages[0] == $past(din))); // R6

endmodule

// File: rtl/vsr_tap.sv
// Module: vsr_tap
// Picks the output stage from the length code and drives q and q_n.
// Clear overrides both outputs combinationally.
// When DEPTH is a power of two the code indexes the chain directly.
// Otherwise codes past the end are clamped to the last stage.
module vsr_tap #(
    parameter int DEPTH = 64,
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DEPTH-1:0] stages,
    input  logic [SEL_W-1:0] len_sel,
    output logic             q,
    output logic             q_n
);

    logic tap;

    // Select the tap; the generate branch is picked by the depth.
    if ((1 << SEL_W) == DEPTH) begin : g_pow2
        assign tap = stages[len_sel];
    end else begin : g_clamp
        assign tap = (int'(len_sel) < DEPTH) ? stages[len_sel] : stages[DEPTH-1];
    end

    // Drive the true and inverse outputs; clear dominates both.
    always_comb begin
        q   = tap & ~clr;
        q_n = ~tap | clr;
    end

    AST_OUTPUTS_INVERSE: assert property (@(posedge clk) disable iff (!rst_n) q_n != q); // R8
    AST_CLEAR_FORCES_OUT: assert property (@(posedge clk) disable iff (!rst_n) clr |-> (!q && q_n)); // R7

endmodule

// File: rtl/varlen_shift_reg.sv
// Module: varlen_shift_reg (top)
// Programmable-length serial shift register: length = len_sel + 1.
// A shift request comes from the two strobe pins, through vsr_strobe.
// The shifted bit is din_a or din_b, chosen by sel_a at the shift edge.
// Assumes: single clk domain; clr may change at any time and acts on
// the outputs without a clock edge.
module varlen_shift_reg
    import vsr_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int SEL_W = sel_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] len_sel,
    input  logic             ck_pos,
    input  logic             ck_neg,
    input  logic             sel_a,
    input  logic             din_a,
    input  logic             din_b,
    output logic             q,
    output logic             q_n
);

    logic             step;
    logic             din_sel;
    logic [DEPTH-1:0] stages;

    // Choose the serial source for the next shift.
    always_comb begin
        din_sel = sel_a ? din_a : din_b;
    end

    vsr_strobe i_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .ck_pos (ck_pos),
        .ck_neg (ck_neg),
        .step   (step)
    );

    vsr_chain #(.DEPTH(DEPTH)) i_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .step   (step),
        .din    (din_sel),
        .stages (stages)
    );

    vsr_tap #(.DEPTH(DEPTH), .SEL_W(SEL_W)) i_tap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .stages  (stages),
        .len_sel (len_sel),
        .q       (q),
        .q_n     (q_n)
    );

    AST_SOURCE_A: assert property (@(posedge clk) disable iff (!rst_n) (step && !clr && sel_a) |=> (stages[0] == $past(din_a))); // R6
    AST_SOURCE_B: assert property (@(posedge clk) disable iff (!rst_n) (step && !clr && !sel_a) |=> (stages[0] == $past(din_b))); // R6

endmodule

// File: tb/test_varlen_shift_reg.sv
module test_varlen_shift_reg;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [5:0] len_sel = 6'd0;
    logic       ck_pos = 1'b0;
    logic       ck_neg = 1'b0;
    logic       sel_a = 1'b1;
    logic       din_a = 1'b0;
    logic       din_b = 1'b0;
    logic       q;
    logic       q_n;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    bit    done   = 1'b0;
    string tag    = "R10";
    bit    hist[$];          // reference history, index 0 = newest bit

    varlen_shift_reg i_varlen_shift_reg (
        .clk(clk), .rst_n(rst_n), .clr(clr), .len_sel(len_sel),
        .ck_pos(ck_pos), .ck_neg(ck_neg), .sel_a(sel_a),
        .din_a(din_a), .din_b(din_b), .q(q), .q_n(q_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected q from the reference history and the live length code.
    function automatic logic exp_q();
        int l = int'(len_sel) + 1;
        if (clr) return 1'b0;
        if (l <= hist.size()) return hist[l-1];
        return 1'b0;
    endfunction

    task automatic chk(input string t, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", t, act, exp, $time);
        end
    endtask

    task automatic model_push(input bit b);
        hist.push_front(b);
        if (hist.size() > DEPTH) void'(hist.pop_back());
    endtask

    // Per-cycle comparison against the reference model.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (chk_on) begin
            chk(tag, q, exp_q());
            chk("R8", q_n, ~q);
        end
    end

    // Change the pins at a falling edge, then let two edges pass.
    task automatic set_pins(input logic p, input logic n);
        @(negedge clk);
        ck_pos = p;
        ck_neg = n;
        repeat (2) @(posedge clk);
    endtask

    // Move to the idle level of a mode through non-shifting changes only.
    task automatic to_mode(input int m);
        if (m == 0) begin
            if (ck_pos) set_pins(1'b0, ck_neg);
            if (ck_neg) set_pins(1'b0, 1'b0);
        end else begin
            if (!ck_neg) set_pins(ck_pos, 1'b1);
            if (!ck_pos) set_pins(1'b1, 1'b1);
        end
    endtask

    // One shift in mode m (0: ck_pos rise, 1: ck_neg fall); unused input gets ~b.
    task automatic shift_bit(input int m, input bit b, input bit use_a);
        @(negedge clk);
        sel_a = use_a;
        din_a = use_a ? b : ~b;
        din_b = use_a ? ~b : b;
        if (m == 0) ck_pos = 1'b1; else ck_neg = 1'b0;
        @(posedge clk);
        @(posedge clk);
        model_push(b);
        @(negedge clk);
        if (m == 0) ck_pos = 1'b0; else ck_neg = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        hist.delete();
        repeat (2) @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        @(posedge clk);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R10", q, 1'b0);
        chk("R10", q_n, 1'b1);
        chk_on = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);

        // R1 R2 R3 R6: every length, both modes, both sources
        for (int l = 1; l <= DEPTH; l++) begin
            int m = l % 2;
            tag = (m == 0) ? "R1 R2 R6" : "R1 R3 R6";
            @(negedge clk);
            len_sel = 6'(l - 1);
            do_clear();
            to_mode(m);
            for (int k = 0; k < l + 3; k++) begin
                shift_bit(m, 1'($urandom), ((k / 2) % 2) == 0);
            end
        end

        // R9: fill all 64 stages, sweep the tap with no shifting
        tag = "R9";
        @(negedge clk);
        len_sel = 6'd63;
        to_mode(0);
        for (int k = 0; k < DEPTH; k++) shift_bit(0, 1'($urandom), k[0]);
        for (int l = 0; l < DEPTH; l++) begin
            @(negedge clk);
            len_sel = 6'(l);
            #1;
            chk("R9", q, exp_q());
        end

        // R11: shift lands on the second edge after the pin change
        tag = "R11";
        @(negedge clk);
        len_sel = 6'd0;
        do_clear();
        to_mode(0);
        @(negedge clk);
        sel_a = 1'b1; din_a = 1'b1; din_b = 1'b0; ck_pos = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R11", q, 1'b0);
        @(posedge clk);
        model_push(1'b1);
        #(CLK_PERIOD/4);
        chk("R11", q, 1'b1);
        @(negedge clk);
        ck_pos = 1'b0;
        repeat (2) @(posedge clk);

        // R4: non-qualifying changes with a 1 waiting at both inputs
        tag = "R4";
        do_clear();
        @(negedge clk);
        din_a = 1'b1; din_b = 1'b1;
        set_pins(1'b0, 1'b1);   // ck_neg rise
        set_pins(1'b1, 1'b1);   // ck_pos rise with ck_neg high
        set_pins(1'b0, 1'b1);   // ck_pos fall
        set_pins(1'b0, 1'b0);   // ck_neg fall with ck_pos low
        #(CLK_PERIOD/4);
        chk("R4", q, 1'b0);

        // R5: both qualifying edges at once give one shift
        tag = "R5";
        @(negedge clk);
        len_sel = 6'd1;
        shift_bit(0, 1'b0, 1'b1);
        set_pins(1'b0, 1'b1);
        @(negedge clk);
        sel_a = 1'b1; din_a = 1'b1; din_b = 1'b0;
        ck_pos = 1'b1; ck_neg = 1'b0;
        repeat (2) @(posedge clk);
        model_push(1'b1);
        set_pins(1'b0, 1'b0);
        #(CLK_PERIOD/4);
        chk("R5", q, 1'b0);          // length 2: one shift leaves the 0 at the tap
        @(negedge clk);
        len_sel = 6'd0;
        #1;
        chk("R5", q, 1'b1);

        // R7: clear forces outputs, ignores strobes, no shift on release
        tag = "R7";
        @(negedge clk);
        clr = 1'b1;
        hist.delete();
        #1;
        chk("R7", q, 1'b0);
        chk("R7", q_n, 1'b1);
        ck_pos = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R7", q, 1'b0);
        set_pins(1'b0, 1'b0);

        // R10: reset clears storage and history, pin high at release
        tag = "R10";
        shift_bit(0, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        ck_pos = 1'b1;
        @(posedge clk);
        hist.delete();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R10", q, 1'b0);
        set_pins(1'b0, 1'b0);
        shift_bit(0, 1'b1, 1'b1);
        #(CLK_PERIOD/4);
        chk("R10", q, 1'b1);

        chk_on = 1'b0;
        done   = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule